// File: doc/BRIEF.md
# Power State Transition Interrupt Unit

This block tracks the 2-bit power-state field of a PCI power-management control/status register. A remote bus agent updates that field through a simple write strobe. Every remote write is sorted by its source and target state. A qualifying change sets one of four sticky status flags, one for each target state D0, D1, D2 and D3. Each flag has its own mask bit. The unmasked flags are combined into one registered interrupt line for the local processor.

Local software works through a separate small register port. It can read the current power state, read the flags and clear them by writing ones, and read and write the mask. The field is held by a four-state machine with the states `PS_D0`, `PS_D1`, `PS_D2` and `PS_D3`. Only a remote write moves it.

The interrupt-raising transitions are:
- `wake`: D1, D2 or D3 to D0.
- `doze`: D0 to D1.
- `nap`: D0 or D1 to D2.
- `off`: D0, D1 or D2 to D3.

The quiet transitions are:
- `demote`: D2 to D1, D3 to D1 and D3 to D2.
- `hold`: the same state written again.

Quiet transitions still move the state but raise nothing.

Top module: `pwr_state_irq`

## Requirements
- R1: A remote write of D0 (code 00) while the state is D1, D2 or D3 sets status bit 0.
- R2: A remote write of D1 (code 01) sets status bit 1 only when the state is D0.
- R3: A remote write of D2 (code 10) while the state is D0 or D1 sets status bit 2.
- R4: A remote write of D3 (code 11) while the state is D0, D1 or D2 sets status bit 3.
- R5: A remote write to the same state, or a demote (D2 to D1, D3 to D1, D3 to D2), sets no flag, but the state still takes the written value.
- R6: After reset the state reads D0 and the status, mask and irq are all 0. Reset never produces a D0 flag.
- R7: Status flags are sticky. Writing 1 to bit i at local address 1 clears flag i, and bits written 0 are untouched.
- R8: When a flag is set and cleared in the same cycle, it ends up set.
- R9: Mask bit i (local address 2, read/write) set to 1 blocks flag i from irq. irq is registered and equals the OR of status AND NOT mask from the previous cycle.
- R10: Local reads are combinational: address 0 returns {00, state}, address 1 the status, address 2 the mask and address 3 zero. Local writes to addresses 0 and 3 change nothing. Only a remote write changes the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_wr_en | input | 1 | Remote write strobe for the power-state field |
| ext_wr_state | input | 2 | Power state being written (00=D0 .. 11=D3) |
| loc_addr | input | 2 | Local register address |
| loc_wr_en | input | 1 | Local write strobe |
| loc_wdata | input | 4 | Local write data |
| loc_rdata | output | 4 | Local read data for loc_addr |
| irq | output | 1 | Registered combined interrupt |

## Verification
A wrong state-machine state shows up on the next remote write as a missing or extra flag, and in the same cycle on address 0. A flag set, lost or cleared wrongly can be seen on address 1 one clock after the write that caused it. On irq it appears one clock later still. A bad mask or combine stage shows on irq exactly one cycle after the status or mask changes, so the bench samples irq at that cycle and again after holding steady.

// File: rtl/pm_irq_pkg.sv
package pm_irq_pkg;
    localparam int PS_W   = 2;
    localparam int NUM_PS = 1 << PS_W;
    localparam int LOC_AW = 2;
    localparam int DATA_W = NUM_PS;

    typedef enum logic [PS_W-1:0] {
        PS_D0 = 2'b00,
        PS_D1 = 2'b01,
        PS_D2 = 2'b10,
        PS_D3 = 2'b11
    } pstate_e;

    localparam logic [LOC_AW-1:0] A_STATE  = 2'd0;
    localparam logic [LOC_AW-1:0] A_STATUS = 2'd1;
    localparam logic [LOC_AW-1:0] A_MASK   = 2'd2;
endpackage

// File: rtl/pm_state_fsm.sv
module pm_state_fsm
    import pm_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [PS_W-1:0]     wr_state,
    output logic [PS_W-1:0]     state_o,
    output logic [NUM_PS-1:0]   event_o
);
    pstate_e cur_q, nxt, tgt;

    assign tgt = pstate_e'(wr_state);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= PS_D0;
        else        cur_q <= nxt;
    end

    always_comb begin
        nxt = cur_q;
        if (wr_en) nxt = tgt;
    end

    // transition classification (outputs)
    always_comb begin
        event_o = '0;
        if (wr_en && tgt != cur_q) begin
            unique case (cur_q)
                PS_D0: begin
                    // doze, nap, off
                    event_o[tgt] = 1'b1;
                end
                PS_D1: begin
                    // wake, nap, off
                    if (tgt != PS_D1) event_o[tgt] = 1'b1;
                end
                PS_D2: begin
                    // wake, off; D2->D1 is a demote
                    if (tgt == PS_D0 || tgt == PS_D3) event_o[tgt] = 1'b1;
                end
                PS_D3: begin
                    // wake only; D3->D1, D3->D2 are demotes
                    if (tgt == PS_D0) event_o[PS_D0] = 1'b1;
                end
            endcase
        end
    end

    assign state_o = cur_q;
endmodule

// File: rtl/pm_status_bank.sv
module pm_status_bank
    import pm_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PS-1:0] set_i,
    input  logic [NUM_PS-1:0] clr_i,
    input  logic              mask_we,
    input  logic [NUM_PS-1:0] mask_d,
    output logic [NUM_PS-1:0] status_o,
    output logic [NUM_PS-1:0] mask_o
);
    genvar i;
    generate
        for (i = 0; i < NUM_PS; i++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    status_o[i] <= 1'b0;
                else if (set_i[i])
                    status_o[i] <= 1'b1;        // set beats clear
                else if (clr_i[i])
                    status_o[i] <= 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_o <= '0;
        else if (mask_we) mask_o <= mask_d;
    end
endmodule

// File: rtl/pm_irq_merge.sv
module pm_irq_merge
    import pm_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PS-1:0] status_i,
    input  logic [NUM_PS-1:0] mask_i,
    output logic              irq_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(status_i & ~mask_i);
    end
endmodule

// File: rtl/pwr_state_irq.sv
module pwr_state_irq
    import pm_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_wr_en,
    input  logic [PS_W-1:0]   ext_wr_state,
    input  logic [LOC_AW-1:0] loc_addr,
    input  logic              loc_wr_en,
    input  logic [DATA_W-1:0] loc_wdata,
    output logic [DATA_W-1:0] loc_rdata,
    output logic              irq
);
    logic [PS_W-1:0]   state_q;
    logic [NUM_PS-1:0] event_w;
    logic [NUM_PS-1:0] status_q;
    logic [NUM_PS-1:0] mask_q;
    logic [NUM_PS-1:0] clr_vec;
    logic              mask_we;

    assign clr_vec = (loc_wr_en && loc_addr == A_STATUS) ? loc_wdata : '0;
    assign mask_we = loc_wr_en && loc_addr == A_MASK;

    pm_state_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ext_wr_en),
        .wr_state (ext_wr_state),
        .state_o  (state_q),
        .event_o  (event_w)
    );

    pm_status_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (event_w),
        .clr_i    (clr_vec),
        .mask_we  (mask_we),
        .mask_d   (loc_wdata),
        .status_o (status_q),
        .mask_o   (mask_q)
    );

    pm_irq_merge u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_q),
        .mask_i   (mask_q),
        .irq_o    (irq)
    );

    always_comb begin
        unique case (loc_addr)
            A_STATE:  loc_rdata = {{(DATA_W-PS_W){1'b0}}, state_q};
            A_STATUS: loc_rdata = status_q;
            A_MASK:   loc_rdata = mask_q;
            default:  loc_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pm_irq_chk.sv
module pm_irq_chk
    import pm_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ext_wr_en,
    input logic [PS_W-1:0]   state_q,
    input logic [NUM_PS-1:0] status_q,
    input logic [NUM_PS-1:0] mask_q,
    input logic [NUM_PS-1:0] clr_vec,
    input logic              irq
);
    p_wake_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[0]) |-> ($past(state_q) != 2'b00 && state_q == 2'b00));

    p_doze_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[1]) |-> ($past(state_q) == 2'b00 && state_q == 2'b01));

    p_nap_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[2]) |-> ($past(state_q) <= 2'b01 && state_q == 2'b10));

    p_off_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[3]) |-> ($past(state_q) != 2'b11 && state_q == 2'b11));

    p_flag_needs_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q)) != '0) |-> $past(ext_wr_en));

    p_state_only_remote_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ext_wr_en) |-> $stable(state_q));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((~status_q & $past(status_q) & ~$past(clr_vec)) == '0));

    p_irq_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ($past(status_q & ~mask_q) != '0));
endmodule

bind pwr_state_irq pm_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_wr_en (ext_wr_en),
    .state_q   (state_q),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .clr_vec   (clr_vec),
    .irq       (irq)
);

// File: tb/pwr_state_irq_test.sv
module pwr_state_irq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_wr_en = 1'b0;
    logic [1:0] ext_wr_state = 2'b00;
    logic [1:0] loc_addr = 2'd0;
    logic       loc_wr_en = 1'b0;
    logic [3:0] loc_wdata = 4'h0;
    logic [3:0] loc_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwr_state_irq uut (
        .clk(clk), .rst_n(rst_n), .ext_wr_en(ext_wr_en), .ext_wr_state(ext_wr_state),
        .loc_addr(loc_addr), .loc_wr_en(loc_wr_en), .loc_wdata(loc_wdata),
        .loc_rdata(loc_rdata), .irq(irq)
    );

    // {written state, expected status afterwards}, starting from D0
    localparam logic [5:0] VEC [16] = '{
        {2'd1, 4'b0010}, {2'd2, 4'b0100}, {2'd1, 4'b0000}, {2'd3, 4'b1000},
        {2'd2, 4'b0000}, {2'd3, 4'b1000}, {2'd1, 4'b0000}, {2'd1, 4'b0000},
        {2'd0, 4'b0001}, {2'd2, 4'b0100}, {2'd0, 4'b0001}, {2'd3, 4'b1000},
        {2'd0, 4'b0001}, {2'd0, 4'b0000}, {2'd3, 4'b1000}, {2'd3, 4'b0000}
    };

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic ext_write(input logic [1:0] s);
        @(negedge clk); ext_wr_en = 1'b1; ext_wr_state = s;
        @(negedge clk); ext_wr_en = 1'b0;
    endtask

    task automatic loc_write(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk); loc_wr_en = 1'b1; loc_addr = a; loc_wdata = d;
        @(negedge clk); loc_wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [3:0] d);
        loc_addr = a; #1; d = loc_rdata;
    endtask

    function automatic string tag_of(input logic [3:0] e);
        if (e[0]) return "R1";
        if (e[1]) return "R2";
        if (e[2]) return "R3";
        if (e[3]) return "R4";
        return "R5";
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [3:0] d;
        repeat (3) @(negedge clk);
        read_reg(2'd0, d); check("R6 state after reset", d, 4'b0000);
        read_reg(2'd1, d); check("R6 status after reset", d, 4'b0000);
        read_reg(2'd2, d); check("R6 mask after reset", d, 4'b0000);
        check("R6 irq after reset", {3'b0, irq}, 4'b0000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        read_reg(2'd1, d); check("R6 no D0 flag after reset release", d, 4'b0000);
        check("R6 irq idle", {3'b0, irq}, 4'b0000);

        // table walk
        foreach (VEC[k]) begin
            ext_write(VEC[k][5:4]);
            read_reg(2'd0, d); check("R10 state readback", d, {2'b00, VEC[k][5:4]});
            read_reg(2'd1, d); check(tag_of(VEC[k][3:0]), d, VEC[k][3:0]);
            @(negedge clk);
            check("R9 irq follows status", {3'b0, irq}, {3'b0, VEC[k][3:0] != 4'b0});
            loc_write(2'd1, 4'hF);
        end
        repeat (2) @(negedge clk);

        // R7 sticky and selective clear: state is D3 now
        ext_write(2'd0);            // wake
        ext_write(2'd3);            // off
        repeat (5) @(negedge clk);
        read_reg(2'd1, d); check("R7 flags held", d, 4'b1001);
        loc_write(2'd1, 4'b0001);
        read_reg(2'd1, d); check("R7 clear bit0 only", d, 4'b1000);
        loc_write(2'd1, 4'b1000);
        read_reg(2'd1, d); check("R7 clear bit3", d, 4'b0000);

        // R8 set wins over clear in same cycle
        ext_write(2'd0);
        loc_write(2'd1, 4'hF);
        @(negedge clk);
        ext_wr_en = 1'b1; ext_wr_state = 2'd1;
        loc_wr_en = 1'b1; loc_addr = 2'd1; loc_wdata = 4'b0010;
        @(negedge clk);
        ext_wr_en = 1'b0; loc_wr_en = 1'b0;
        read_reg(2'd1, d); check("R8 set wins", d, 4'b0010);
        loc_write(2'd1, 4'hF);

        // R9 masking
        loc_write(2'd2, 4'b0100);
        read_reg(2'd2, d); check("R9 mask readback", d, 4'b0100);
        ext_write(2'd2);            // nap from D1
        repeat (3) @(negedge clk);
        read_reg(2'd1, d); check("R9 masked flag still recorded", d, 4'b0100);
        check("R9 masked irq low", {3'b0, irq}, 4'b0000);
        loc_write(2'd2, 4'b0000);
        check("R9 irq one cycle after unmask still low", {3'b0, irq}, 4'b0000);
        @(negedge clk);
        check("R9 irq rises after unmask", {3'b0, irq}, 4'b0001);
        loc_write(2'd1, 4'hF);
        @(negedge clk);
        check("R9 irq low after clear", {3'b0, irq}, 4'b0000);

        // R10 writes to state and spare address ignored
        loc_write(2'd0, 4'b0011);
        read_reg(2'd0, d); check("R10 state not locally writable", d, 4'b0010);
        loc_write(2'd3, 4'hF);
        read_reg(2'd3, d); check("R10 spare reads zero", d, 4'b0000);
        read_reg(2'd2, d); check("R10 spare write leaves mask", d, 4'b0000);
        read_reg(2'd1, d); check("R10 spare write leaves status", d, 4'b0000);

        // R6 reset mid-run while in D3 with a flag pending
        ext_write(2'd3);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        read_reg(2'd0, d); check("R6 state back to D0", d, 4'b0000);
        read_reg(2'd1, d); check("R6 no flag after re-reset", d, 4'b0000);
        check("R6 irq after re-reset", {3'b0, irq}, 4'b0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule